// File: doc/BRIEF.md
# Four-Phase Program Counter Sequencer

This block sets the instruction-cycle timing for a small 8-bit controller core and picks the next program address. It splits the system clock into four phase strobes, T1 to T4. One full pass through the four phases is one instruction cycle. The program counter changes only on the clock edge that ends T4, so the new address is ready at the start of T1, when the next fetch begins.

At that edge the block picks a source for the program counter. The choices are: a fixed vector for an external or timer interrupt, a jump or call target, a return address from the stack top, a write to the low byte of the counter, a skip, or a plain increment. Any change of flow starts a dummy cycle, and the `flush` output flags it for one full instruction cycle. In that cycle the fetched word acts as a no-operation. The block ignores every strobe and request during it and simply increments the counter. The `t1_sync` output gives a T1 pulse at one quarter of the clock rate.

Top module: `pc_sequencer`

## Requirements
- R1: `phase` is one-hot. After reset it shows T1 (`phase[0]`) and then steps T1, T2, T3, T4 (`phase[3]`) and back to T1, one step per clock. One instruction cycle is four clocks.
- R2: `t1_sync` is high for exactly one clock in every four, during T1.
- R3: `pc` and `flush` change only on the clock edge where `phase` is T4 before the edge.
- R4: Reset is synchronous and active high. It sets `pc` to 0x000, sets `phase` to T1 and clears `flush`, and it holds them there while asserted, even when asserted mid-cycle.
- R5: With no strobe active, `pc` increments by 1 per instruction cycle and wraps from all-ones to 0. `flush` stays low.
- R6: `skip_ok` advances `pc` by 2 and sets `flush`.
- R7: `jmp_req` (jump or call) loads `jmp_target` in full and sets `flush`.
- R8: `ret_req` loads `stack_top` and sets `flush`.
- R9: `pcl_wr` replaces `pc[7:0]` with `pcl_data`, keeps `pc[PC_W-1:8]` unchanged, and sets `flush`.
- R10: `ext_irq` loads 0x004 and `tmr_irq` loads 0x008. Both set `flush`.
- R11: When several are active at the T4 edge, priority from highest to lowest is `ext_irq`, `tmr_irq`, `jmp_req`, `ret_req`, `pcl_wr`, `skip_ok`.
- R12: `flush` stays high for exactly one instruction cycle. At the T4 edge that ends that cycle, all strobes and interrupt requests are ignored: `pc` increments by 1 and `flush` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq | input | 1 | External interrupt request, held by its source until serviced |
| tmr_irq | input | 1 | Timer overflow interrupt request |
| jmp_req | input | 1 | Decoded jump or call |
| ret_req | input | 1 | Decoded return |
| pcl_wr | input | 1 | Decoded write of the counter low byte |
| skip_ok | input | 1 | Conditional skip taken |
| jmp_target | input | PC_W | Immediate target of jump or call |
| stack_top | input | PC_W | Return address at the top of the stack |
| pcl_data | input | 8 | Value written to the counter low byte |
| phase | output | 4 | One-hot phase strobes, bit 0 is T1 |
| pc | output | PC_W | Program counter |
| flush | output | 1 | Current instruction cycle is a dummy cycle |
| t1_sync | output | 1 | T1 pulse, 1 high to 3 low |

## Verification
If the phase ring lost its one-hot state, `t1_sync` and `phase` would show it within one clock, and `pc` would stop updating or update at the wrong point within four clocks. A wrong source choice or a wrong priority shows up in `pc` at the first T1 after the strobe. A `flush` that lasts too long or ends too early shows up in the next instruction cycle: the strobes applied in that cycle are either ignored when they should act, or act when they should be ignored. The bench checks `pc`, `flush` and `phase` at every T1 boundary, so every fault surfaces within one instruction cycle of its cause.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned RST_VEC    = 'h000;
  localparam int unsigned EXT_VEC    = 'h004;
  localparam int unsigned TMR_VEC    = 'h008;
  localparam int unsigned BYTE_W     = 8;

  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_SKIP = 3'd1,
    SRC_PCL  = 3'd2,
    SRC_RET  = 3'd3,
    SRC_JMP  = 3'd4,
    SRC_TMR  = 3'd5,
    SRC_EXT  = 3'd6
  } pc_src_e;
endpackage

// File: rtl/pc_phase_ring.sv
module pc_phase_ring import pc_seq_pkg::*; (
  input  logic                  clk,
  input  logic                  rst,
  output logic [NUM_PHASES-1:0] ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= NUM_PHASES'(1);
    else     ph <= {ph[NUM_PHASES-2:0], ph[NUM_PHASES-1]};
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(ph) == 1);
  assert_phase_rotate_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ph == {$past(ph[NUM_PHASES-2:0]), $past(ph[NUM_PHASES-1])});
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel import pc_seq_pkg::*; #(
  parameter int unsigned PC_W = 11
) (
  input  logic              in_flush,
  input  logic              ext_irq,
  input  logic              tmr_irq,
  input  logic              jmp_req,
  input  logic              ret_req,
  input  logic              pcl_wr,
  input  logic              skip_ok,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [PC_W-1:0]   jmp_target,
  input  logic [PC_W-1:0]   stack_top,
  input  logic [BYTE_W-1:0] pcl_data,
  output logic [PC_W-1:0]   pc_next,
  output logic              redirect
);
  pc_src_e src;

  always_comb begin
    if (in_flush)     src = SRC_INC;
    else if (ext_irq) src = SRC_EXT;
    else if (tmr_irq) src = SRC_TMR;
    else if (jmp_req) src = SRC_JMP;
    else if (ret_req) src = SRC_RET;
    else if (pcl_wr)  src = SRC_PCL;
    else if (skip_ok) src = SRC_SKIP;
    else              src = SRC_INC;
  end

  always_comb begin
    case (src)
      SRC_EXT:  pc_next = PC_W'(EXT_VEC);
      SRC_TMR:  pc_next = PC_W'(TMR_VEC);
      SRC_JMP:  pc_next = jmp_target;
      SRC_RET:  pc_next = stack_top;
      SRC_PCL:  pc_next = {pc_cur[PC_W-1:BYTE_W], pcl_data};
      SRC_SKIP: pc_next = pc_cur + PC_W'(2);
      default:  pc_next = pc_cur + PC_W'(1);
    endcase
    redirect = (src != SRC_INC);
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer import pc_seq_pkg::*; #(
  parameter int unsigned PC_W = 11   // 9, 10 or 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_irq,
  input  logic                  tmr_irq,
  input  logic                  jmp_req,
  input  logic                  ret_req,
  input  logic                  pcl_wr,
  input  logic                  skip_ok,
  input  logic [PC_W-1:0]       jmp_target,
  input  logic [PC_W-1:0]       stack_top,
  input  logic [BYTE_W-1:0]     pcl_data,
  output logic [NUM_PHASES-1:0] phase,
  output logic [PC_W-1:0]       pc,
  output logic                  flush,
  output logic                  t1_sync
);
  localparam int unsigned LAST_PH = NUM_PHASES - 1;

  logic [NUM_PHASES-1:0] ph;
  logic [PC_W-1:0]       pc_q, pc_nx;
  logic                  flush_q, redir;
  logic                  cycle_end;

  pc_phase_ring u_ring (
    .clk (clk),
    .rst (rst),
    .ph  (ph)
  );

  assign cycle_end = ph[LAST_PH];

  pc_next_sel #(.PC_W(PC_W)) u_sel (
    .in_flush   (flush_q),
    .ext_irq    (ext_irq),
    .tmr_irq    (tmr_irq),
    .jmp_req    (jmp_req),
    .ret_req    (ret_req),
    .pcl_wr     (pcl_wr),
    .skip_ok    (skip_ok),
    .pc_cur     (pc_q),
    .jmp_target (jmp_target),
    .stack_top  (stack_top),
    .pcl_data   (pcl_data),
    .pc_next    (pc_nx),
    .redirect   (redir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= PC_W'(RST_VEC);
      flush_q <= 1'b0;
    end else if (cycle_end) begin
      pc_q    <= pc_nx;
      flush_q <= redir;
    end
  end

  assign phase   = ph;
  assign pc      = pc_q;
  assign flush   = flush_q;
  assign t1_sync = ph[0];

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !phase[LAST_PH] |=> $stable(pc) && $stable(flush));
  assert_t1_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    t1_sync |=> !t1_sync);
  assert_flush_once_R12: assert property (@(posedge clk) disable iff (rst)
    flush && phase[LAST_PH] |=> !flush && pc == $past(pc) + PC_W'(1));
  assert_ext_vector_R10: assert property (@(posedge clk) disable iff (rst)
    phase[LAST_PH] && !flush && ext_irq |=> pc == PC_W'(EXT_VEC) && flush);
  assert_pcl_page_R9: assert property (@(posedge clk) disable iff (rst)
    phase[LAST_PH] && !flush && pcl_wr && !ext_irq && !tmr_irq && !jmp_req && !ret_req
    |=> pc[PC_W-1:BYTE_W] == $past(pc[PC_W-1:BYTE_W]) && flush);
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam int PC_W = 11;
  localparam int NV   = 27;
  // {req[51:48], ctrl{ext,tmr,jmp,ret,pcl,skip}[47:42], target[41:31], stack[30:20], pcl[19:12], exp_pc[11:1], exp_flush[0]}
  localparam logic [51:0] VEC [NV] = '{
    {4'd5,  6'b000000, 11'h000, 11'h000, 8'h00, 11'h001, 1'b0}, // R5
    {4'd5,  6'b000000, 11'h000, 11'h000, 8'h00, 11'h002, 1'b0}, // R5
    {4'd6,  6'b000001, 11'h000, 11'h000, 8'h00, 11'h004, 1'b1}, // R6
    {4'd12, 6'b001000, 11'h100, 11'h000, 8'h00, 11'h005, 1'b0}, // R12 jump ignored
    {4'd7,  6'b001000, 11'h123, 11'h000, 8'h00, 11'h123, 1'b1}, // R7
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h124, 1'b0}, // R12
    {4'd9,  6'b000010, 11'h000, 11'h000, 8'h80, 11'h180, 1'b1}, // R9
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h181, 1'b0},
    {4'd8,  6'b000100, 11'h000, 11'h055, 8'h00, 11'h055, 1'b1}, // R8
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h056, 1'b0},
    {4'd10, 6'b010000, 11'h000, 11'h000, 8'h00, 11'h008, 1'b1}, // R10 timer
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h009, 1'b0},
    {4'd11, 6'b110000, 11'h000, 11'h000, 8'h00, 11'h004, 1'b1}, // R11 ext over timer
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h005, 1'b0},
    {4'd7,  6'b001000, 11'h7FF, 11'h000, 8'h00, 11'h7FF, 1'b1}, // R7 full width
    {4'd5,  6'b000000, 11'h000, 11'h000, 8'h00, 11'h000, 1'b0}, // R5 wrap
    {4'd9,  6'b000010, 11'h000, 11'h000, 8'hFF, 11'h0FF, 1'b1}, // R9 page 0
    {4'd5,  6'b000000, 11'h000, 11'h000, 8'h00, 11'h100, 1'b0},
    {4'd11, 6'b001100, 11'h200, 11'h3AA, 8'h00, 11'h200, 1'b1}, // R11 jump over return
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h201, 1'b0},
    {4'd11, 6'b000011, 11'h000, 11'h000, 8'h10, 11'h210, 1'b1}, // R11 pcl over skip
    {4'd12, 6'b100000, 11'h000, 11'h000, 8'h00, 11'h211, 1'b0}, // R12 irq ignored
    {4'd10, 6'b100000, 11'h000, 11'h000, 8'h00, 11'h004, 1'b1}, // R10 external
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h005, 1'b0},
    {4'd11, 6'b011000, 11'h300, 11'h000, 8'h00, 11'h008, 1'b1}, // R11 timer over jump
    {4'd12, 6'b000000, 11'h000, 11'h000, 8'h00, 11'h009, 1'b0},
    {4'd11, 6'b000101, 11'h000, 11'h040, 8'h00, 11'h040, 1'b1}  // R11 return over skip
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_irq = 0, tmr_irq = 0, jmp_req = 0, ret_req = 0, pcl_wr = 0, skip_ok = 0;
  logic [PC_W-1:0] jmp_target = '0, stack_top = '0;
  logic [7:0] pcl_data = '0;
  logic [3:0] phase;
  logic [PC_W-1:0] pc;
  logic flush, t1_sync;
  int tests = 0, failed = 0;

  always #5 clk = ~clk;

  pc_sequencer #(.PC_W(PC_W)) u_pc_sequencer (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
    .jmp_req(jmp_req), .ret_req(ret_req), .pcl_wr(pcl_wr), .skip_ok(skip_ok),
    .jmp_target(jmp_target), .stack_top(stack_top), .pcl_data(pcl_data),
    .phase(phase), .pc(pc), .flush(flush), .t1_sync(t1_sync)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2000000;
    failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    int ones;
    repeat (2) @(negedge clk);
    chk("R4", "reset phase", 32'(phase), 32'h1);
    chk("R4", "reset pc", 32'(pc), 32'h0);
    chk("R4", "reset flush", 32'(flush), 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][51:48]);
      {ext_irq, tmr_irq, jmp_req, ret_req, pcl_wr, skip_ok} = VEC[i][47:42];
      jmp_target = VEC[i][41:31];
      stack_top  = VEC[i][30:20];
      pcl_data   = VEC[i][19:12];
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (i > 0) chk("R3", "pc mid-cycle", 32'(pc), 32'(VEC[i-1][11:1]));
      end
      @(negedge clk);
      chk(rq, $sformatf("vector %0d pc", i), 32'(pc), 32'(VEC[i][11:1]));
      chk(rq, $sformatf("vector %0d flush", i), 32'(flush), 32'(VEC[i][0]));
      chk("R1", "phase at cycle start", 32'(phase), 32'h1);
    end
    {ext_irq, tmr_irq, jmp_req, ret_req, pcl_wr, skip_ok} = '0;

    // R2: duty of t1_sync and phase order over two cycles
    ones = 0;
    for (int k = 0; k < 8; k++) begin
      if (t1_sync) ones++;
      chk("R1", "phase step", 32'(phase), 32'(4'b0001 << (k % 4)));
      @(negedge clk);
    end
    chk("R2", "t1_sync high count over 8 clocks", 32'(ones), 32'd2);

    // R4: reset applied mid-cycle at T3
    repeat (2) @(negedge clk);
    chk("R1", "phase T3 before reset", 32'(phase), 32'h4);
    rst = 1'b1;
    @(negedge clk);
    chk("R4", "mid-cycle reset phase", 32'(phase), 32'h1);
    chk("R4", "mid-cycle reset pc", 32'(pc), 32'h0);
    chk("R4", "mid-cycle reset flush", 32'(flush), 32'h0);
    @(negedge clk);
    chk("R4", "reset held phase", 32'(phase), 32'h1);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3", "pc held before T4 edge", 32'(pc), 32'h0);
    end
    @(negedge clk);
    chk("R5", "first increment after reset", 32'(pc), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule